// File: doc/BRIEF.md
# Complex Butterfly and Multiply-Accumulate Datapath

This block is a register-mapped arithmetic unit for radix-2 FFT butterflies and complex multiply-accumulate work. Software (or a sequencer) writes complex words into four input ports, numbered 0 to 3, and reads four complex results back. A write to port 3 is the "step" event. It multiplies the current port 2 and port 3 inputs in a complex multiplier. It runs a sum adder and a difference adder. It shifts the previous adder results into two hold registers and reloads the adder operand registers. All of this happens in one clock.

A control word chooses the behaviour of each step. It selects the operand sources, the direction of each adder, the multiplier conjugation mode, halving and rounding on the adder outputs, side effects of port writes, and what each read port shows. Four sticky flags accumulate across steps. Two mark adder results that have grown past half of full scale, which a block-floating-point FFT can use to decide when to rescale. Two mark any saturation in the adders or the multiplier.

Complex words are 2·W bits. The real part sits in the upper half and the imaginary part in the lower half. Each part is a two's complement fraction with W-1 fraction bits.

Top module: `cbfly_unit`

## Requirements
- R1: While rst_n is low, and right after reset, all four read ports are zero and all four flags are zero.
- R2: When wr_en is high, wr_addr 0..3 loads port inputs P0..P3 with wr_data. With cfg[16]=0, rd_p0/rd_p1 show P0/P1 on the next cycle. With cfg[17]=0, rd_p2/rd_p3 show P2/P3 on the next cycle. With cfg[3]=1, a write to port 1 also loads P0.
- R3: A write to port 3 also acts on P2, as set by cfg[7:6]. 0 leaves P2 unchanged. 1 copies wr_data into P2. 2 loads coef_in into P2. 3 leaves P2 unchanged.
- R4: The multiplier forms a product from P2 (x) and P3 (y), as set by cfg[5:4]. 0 gives x·y. 1 gives conj(x)·y. 2 gives x·conj(y). 3 gives Re(x)·Re(y) as the real part and Im(x)·Im(y) as the imaginary part. Each part is arithmetically shifted right by W-1 and saturated to W bits.
- R5: A step (a write to port 3 with cfg[0]=0) updates the internal registers from their values before the write. Register A takes the source picked by cfg[9:8] and register B the source picked by cfg[11:10] (source codes: 0 zero, 1 P0, 2 S, 3 zero). S takes the sum-adder result. D takes the difference-adder result. Q takes the old S, R takes the old D, and L takes the product. Without a step these registers hold.
- R6: The sum adder combines A with the second operand, as set by cfg[13:12]. The difference adder combines B with the second operand, as set by cfg[15:14]. The codes are 0 op+second, 1 op−second, 2 second−op, 3 same as 0.
- R7: With cfg[1]=1, each adder part becomes (raw + cfg[2]) arithmetically shifted right by 1. With cfg[1]=0, the part is the raw value and cfg[2] has no effect. Every part saturates to the W-bit range.
- R8: On each step, sat_re/sat_im are set if the real/imaginary part of either adder or of the product saturated. They stay set until cleared.
- R9: On each step, big_re is set if the real part of the new S or of the new D lies outside [-0.5, 0.5), meaning its top two bits differ. big_im does the same for the imaginary parts. These flags are sticky, and only a step sets any flag.
- R10: cfg[0]=1 at a clock edge zeroes A, B, S, D, Q, R, L and all four flags. This overrides a step. Port input writes still take place.
- R11: With cfg[16]=1, rd_p0/rd_p1 show Q/R. With cfg[17]=1, rd_p2 shows the live product of the current P2 and P3, and rd_p3 shows L.
- R12: With cfg[18]=1, both adders take L as their second operand. With cfg[18]=0, they take the live product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Port write strobe |
| wr_addr | input | 2 | Port number written |
| wr_data | input | 2*W | Complex word written |
| coef_in | input | 2*W | Coefficient word for P2 loading on a step |
| cfg | input | 19 | Control word |
| rd_p0 | output | 2*W | Read port 0 (P0 or Q) |
| rd_p1 | output | 2*W | Read port 1 (P1 or R) |
| rd_p2 | output | 2*W | Read port 2 (P2 or live product) |
| rd_p3 | output | 2*W | Read port 3 (P3 or L) |
| big_re | output | 1 | Sticky real large-value flag |
| big_im | output | 1 | Sticky imaginary large-value flag |
| sat_re | output | 1 | Sticky real saturation flag |
| sat_im | output | 1 | Sticky imaginary saturation flag |

## Verification
The properties assume that every input is a known value at each clock edge and that wr_addr is meaningful whenever wr_en is high. They also assume that the control word, as seen at an edge, is the one that governs that edge's update. The stimulus changes all inputs only on the falling edge. It draws the P2 side-effect field only from the defined codes 0 to 2, and it asserts the clear bit only now and then, so the sticky flags get a chance to build up between clears.

// File: rtl/cbfly_pkg.sv
package cbfly_pkg;

  typedef enum logic [1:0] {SRC_ZERO = 2'd0, SRC_P0 = 2'd1, SRC_S = 2'd2, SRC_NONE = 2'd3} src_e;
  typedef enum logic [1:0] {FN_ADD = 2'd0, FN_SUB = 2'd1, FN_RSUB = 2'd2, FN_ADD2 = 2'd3} fn_e;
  typedef enum logic [1:0] {SIDE_NONE = 2'd0, SIDE_COPY = 2'd1, SIDE_COEF = 2'd2, SIDE_RSV = 2'd3} side_e;
  typedef enum logic [1:0] {MUL_PLAIN = 2'd0, MUL_CONJX = 2'd1, MUL_CONJY = 2'd2, MUL_SPLIT = 2'd3} mul_e;

  typedef struct packed {
    logic  use_l;
    logic  rd_mp;
    logic  rd_qr;
    fn_e   d_fn;
    fn_e   s_fn;
    src_e  b_sel;
    src_e  a_sel;
    side_e p3_side;
    mul_e  mul_mode;
    logic  dup01;
    logic  rnd;
    logic  halve;
    logic  clear;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/cbfly_cmul.sv
module cbfly_cmul #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] x,
  input  logic [2*W-1:0] y,
  input  cbfly_pkg::mul_e mode,
  output logic [2*W-1:0] p,
  output logic [1:0]     sat
);
  import cbfly_pkg::*;

  localparam int PW = 2*W + 1;
  localparam logic signed [PW-1:0] MAXV = {{(W+2){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = -MAXV - 1;

  logic signed [2*W-1:0] xr, xi, yr, yi;
  logic signed [2*W-1:0] rr, ii, ri, ir;
  logic signed [PW-1:0]  raw [2];

  assign xr = {{W{x[2*W-1]}}, x[2*W-1:W]};
  assign xi = {{W{x[W-1]}},   x[W-1:0]};
  assign yr = {{W{y[2*W-1]}}, y[2*W-1:W]};
  assign yi = {{W{y[W-1]}},   y[W-1:0]};

  assign rr = xr * yr;
  assign ii = xi * yi;
  assign ri = xr * yi;
  assign ir = xi * yr;

  // raw[1] is the real lane, raw[0] the imaginary lane
  always_comb begin
    unique case (mode)
      MUL_PLAIN: begin
        raw[1] = {rr[2*W-1], rr} - {ii[2*W-1], ii};
        raw[0] = {ri[2*W-1], ri} + {ir[2*W-1], ir};
      end
      MUL_CONJX: begin
        raw[1] = {rr[2*W-1], rr} + {ii[2*W-1], ii};
        raw[0] = {ri[2*W-1], ri} - {ir[2*W-1], ir};
      end
      MUL_CONJY: begin
        raw[1] = {rr[2*W-1], rr} + {ii[2*W-1], ii};
        raw[0] = {ir[2*W-1], ir} - {ri[2*W-1], ri};
      end
      default: begin
        raw[1] = {rr[2*W-1], rr};
        raw[0] = {ii[2*W-1], ii};
      end
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [PW-1:0] sh;
    assign sh = raw[g] >>> (W-1);
    always_comb begin
      if (sh > MAXV) begin
        p[g*W +: W] = MAXV[W-1:0];
        sat[g]      = 1'b1;
      end else if (sh < MINV) begin
        p[g*W +: W] = MINV[W-1:0];
        sat[g]      = 1'b1;
      end else begin
        p[g*W +: W] = sh[W-1:0];
        sat[g]      = 1'b0;
      end
    end
  end

endmodule

// File: rtl/cbfly_addsub.sv
module cbfly_addsub #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] op,
  input  logic [2*W-1:0] sec,
  input  cbfly_pkg::fn_e fn,
  input  logic           halve,
  input  logic           rnd,
  output logic [2*W-1:0] y,
  output logic [1:0]     sat,
  output logic [1:0]     big
);
  import cbfly_pkg::*;

  localparam int EW = W + 2;
  localparam logic signed [EW-1:0] MAXV = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [EW-1:0] MINV = -MAXV - 1;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [EW-1:0] e1, e2, sum, rsum, v;
    logic [W-1:0] res;

    assign e1 = {{2{op[g*W+W-1]}},  op[g*W +: W]};
    assign e2 = {{2{sec[g*W+W-1]}}, sec[g*W +: W]};

    always_comb begin
      unique case (fn)
        FN_SUB:  sum = e1 - e2;
        FN_RSUB: sum = e2 - e1;
        default: sum = e1 + e2;
      endcase
      rsum = sum + {{(EW-1){1'b0}}, rnd};
      v    = halve ? (rsum >>> 1) : sum;
    end

    always_comb begin
      if (v > MAXV) begin
        res    = MAXV[W-1:0];
        sat[g] = 1'b1;
      end else if (v < MINV) begin
        res    = MINV[W-1:0];
        sat[g] = 1'b1;
      end else begin
        res    = v[W-1:0];
        sat[g] = 1'b0;
      end
    end

    assign y[g*W +: W] = res;
    assign big[g]      = res[W-1] ^ res[W-2];
  end

endmodule

// File: rtl/cbfly_ports.sv
module cbfly_ports #(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [2*W-1:0]  wr_data,
  input  logic [2*W-1:0]  coef_in,
  input  logic            dup01,
  input  cbfly_pkg::side_e p3_side,
  output logic [2*W-1:0]  p0,
  output logic [2*W-1:0]  p1,
  output logic [2*W-1:0]  p2,
  output logic [2*W-1:0]  p3
);
  import cbfly_pkg::*;

  logic           en0, en1, en2, en3;
  logic [2*W-1:0] p2_d;

  always_comb begin
    en1  = wr_en && (wr_addr == 2'd1);
    en3  = wr_en && (wr_addr == 2'd3);
    en0  = (wr_en && (wr_addr == 2'd0)) || (en1 && dup01);
    en2  = 1'b0;
    p2_d = wr_data;
    if (wr_en && (wr_addr == 2'd2)) begin
      en2 = 1'b1;
    end else if (en3 && (p3_side == SIDE_COPY)) begin
      en2 = 1'b1;
    end else if (en3 && (p3_side == SIDE_COEF)) begin
      en2  = 1'b1;
      p2_d = coef_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0 <= '0;
      p1 <= '0;
      p2 <= '0;
      p3 <= '0;
    end else begin
      if (en0) p0 <= wr_data;
      if (en1) p1 <= wr_data;
      if (en2) p2 <= p2_d;
      if (en3) p3 <= wr_data;
    end
  end

endmodule

// File: rtl/cbfly_unit.sv
module cbfly_unit #(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [2*W-1:0]           wr_data,
  input  logic [2*W-1:0]           coef_in,
  input  logic [cbfly_pkg::CFG_W-1:0] cfg,
  output logic [2*W-1:0]           rd_p0,
  output logic [2*W-1:0]           rd_p1,
  output logic [2*W-1:0]           rd_p2,
  output logic [2*W-1:0]           rd_p3,
  output logic                     big_re,
  output logic                     big_im,
  output logic                     sat_re,
  output logic                     sat_im
);
  import cbfly_pkg::*;

  cfg_t c;
  assign c = cfg_t'(cfg);

  logic [2*W-1:0] p0, p1, p2, p3;
  logic [2*W-1:0] a_q, b_q, s_q, d_q, q_q, r_q, l_q;
  logic [2*W-1:0] a_d, b_d, s_d, d_d, q_d, r_d, l_d;
  logic [3:0]     fl_q, fl_d;
  logic [2*W-1:0] prod, sec, s_y, d_y;
  logic [1:0]     m_sat, s_sat, d_sat, s_big, d_big;
  logic           step, upd_en;

  cbfly_ports #(.W(W)) u_ports (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .coef_in (coef_in),
    .dup01   (c.dup01),
    .p3_side (c.p3_side),
    .p0      (p0),
    .p1      (p1),
    .p2      (p2),
    .p3      (p3)
  );

  cbfly_cmul #(.W(W)) u_mul (
    .x    (p2),
    .y    (p3),
    .mode (c.mul_mode),
    .p    (prod),
    .sat  (m_sat)
  );

  assign sec = c.use_l ? l_q : prod;

  cbfly_addsub #(.W(W)) u_sum (
    .op    (a_q),
    .sec   (sec),
    .fn    (c.s_fn),
    .halve (c.halve),
    .rnd   (c.rnd),
    .y     (s_y),
    .sat   (s_sat),
    .big   (s_big)
  );

  cbfly_addsub #(.W(W)) u_dif (
    .op    (b_q),
    .sec   (sec),
    .fn    (c.d_fn),
    .halve (c.halve),
    .rnd   (c.rnd),
    .y     (d_y),
    .sat   (d_sat),
    .big   (d_big)
  );

  function automatic logic [2*W-1:0] pick(src_e sel, logic [2*W-1:0] pv, logic [2*W-1:0] sv);
    unique case (sel)
      SRC_P0:  return pv;
      SRC_S:   return sv;
      default: return '0;
    endcase
  endfunction

  assign step   = wr_en && (wr_addr == 2'd3);
  assign upd_en = step || c.clear;

  // flag order: {big_re, big_im, sat_re, sat_im}
  always_comb begin
    if (c.clear) begin
      a_d  = '0; b_d = '0; s_d = '0; d_d = '0;
      q_d  = '0; r_d = '0; l_d = '0;
      fl_d = '0;
    end else begin
      a_d  = pick(c.a_sel, p0, s_q);
      b_d  = pick(c.b_sel, p0, s_q);
      s_d  = s_y;
      d_d  = d_y;
      q_d  = s_q;
      r_d  = d_q;
      l_d  = prod;
      fl_d = fl_q | {s_big[1] | d_big[1], s_big[0] | d_big[0],
                     s_sat[1] | d_sat[1] | m_sat[1], s_sat[0] | d_sat[0] | m_sat[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0; b_q <= '0; s_q <= '0; d_q <= '0;
      q_q  <= '0; r_q <= '0; l_q <= '0;
      fl_q <= '0;
    end else if (upd_en) begin
      a_q  <= a_d; b_q <= b_d; s_q <= s_d; d_q <= d_d;
      q_q  <= q_d; r_q <= r_d; l_q <= l_d;
      fl_q <= fl_d;
    end
  end

  assign rd_p0  = c.rd_qr ? q_q  : p0;
  assign rd_p1  = c.rd_qr ? r_q  : p1;
  assign rd_p2  = c.rd_mp ? prod : p2;
  assign rd_p3  = c.rd_mp ? l_q  : p3;
  assign big_re = fl_q[3];
  assign big_im = fl_q[2];
  assign sat_re = fl_q[1];
  assign sat_im = fl_q[0];

endmodule

// File: rtl/cbfly_checker.sv
module cbfly_checker #(
  parameter int W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [1:0]                  wr_addr,
  input logic [2*W-1:0]              wr_data,
  input logic [cbfly_pkg::CFG_W-1:0] cfg,
  input logic [2*W-1:0]              rd_p0,
  input logic [2*W-1:0]              rd_p2,
  input logic                        big_re,
  input logic                        big_im,
  input logic                        sat_re,
  input logic                        sat_im
);
  import cbfly_pkg::*;

  cfg_t c;
  assign c = cfg_t'(cfg);

  AST_PORT0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (c.rd_qr || rd_p0 == $past(wr_data))); // R2

  AST_P2_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && c.p3_side == SIDE_COPY) |=> (c.rd_mp || rd_p2 == $past(wr_data))); // R3

  AST_SAT_RE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_re && !c.clear) |=> sat_re); // R8

  AST_SAT_IM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_im && !c.clear) |=> sat_im); // R8

  AST_BIG_RE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (big_re && !c.clear) |=> big_re); // R9

  AST_BIG_IM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (big_im && !c.clear) |=> big_im); // R9

  AST_FLAG_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(big_re) || $rose(big_im) || $rose(sat_re) || $rose(sat_im))
      |-> $past(wr_en && wr_addr == 2'd3)); // R9

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    c.clear |=> !(big_re || big_im || sat_re || sat_im)); // R10

endmodule

bind cbfly_unit cbfly_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .cfg     (cfg),
  .rd_p0   (rd_p0),
  .rd_p2   (rd_p2),
  .big_re  (big_re),
  .big_im  (big_im),
  .sat_re  (sat_re),
  .sat_im  (sat_im)
);

// File: tb/cbfly_unit_test.sv
`timescale 1ns/1ps
module cbfly_unit_test;
  localparam int W  = 16;
  localparam int DW = 2*W;
  localparam int CW = 19;
  localparam int VW = 4*DW + 4;

  localparam logic [CW-1:0] F_CLR = 19'h00001;
  localparam logic [CW-1:0] F_HV  = 19'h00002;
  localparam logic [CW-1:0] F_RD  = 19'h00004;
  localparam logic [CW-1:0] F_DUP = 19'h00008;
  localparam logic [CW-1:0] F_QR  = 19'h10000;
  localparam logic [CW-1:0] F_MP  = 19'h20000;
  localparam logic [CW-1:0] F_UL  = 19'h40000;

  logic          clk, rst_n, wr_en;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data, coef_in;
  logic [CW-1:0] cfg;
  logic [DW-1:0] rd_p0, rd_p1, rd_p2, rd_p3;
  logic          big_re, big_im, sat_re, sat_im;

  cbfly_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .coef_in(coef_in), .cfg(cfg),
    .rd_p0(rd_p0), .rd_p1(rd_p1), .rd_p2(rd_p2), .rd_p3(rd_p3),
    .big_re(big_re), .big_im(big_im), .sat_re(sat_re), .sat_im(sat_im)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic [VW-1:0] v;
    string         tag;
  } item_t;
  item_t sb[$];

  // reference state
  logic [DW-1:0] m_p0, m_p1, m_p2, m_p3, m_a, m_b, m_s, m_d, m_q, m_r, m_l;
  logic [3:0]    m_fl;

  function automatic logic [CW-1:0] fld(int mm, int side, int as_, int bs, int sf, int df);
    logic [CW-1:0] f = '0;
    f[5:4]   = 2'(mm);
    f[7:6]   = 2'(side);
    f[9:8]   = 2'(as_);
    f[11:10] = 2'(bs);
    f[13:12] = 2'(sf);
    f[15:14] = 2'(df);
    return f;
  endfunction

  function automatic longint ln(logic [DW-1:0] x, int g);
    logic [W-1:0] t = x[g*W +: W];
    return longint'($signed(t));
  endfunction

  function automatic logic [W-1:0] msat(longint v, output bit s);
    longint mx = (longint'(1) << (W-1)) - 1;
    longint mn = -mx - 1;
    s = 1'b0;
    if (v > mx) begin s = 1'b1; v = mx; end
    else if (v < mn) begin s = 1'b1; v = mn; end
    return v[W-1:0];
  endfunction

  function automatic logic [DW-1:0] mmul(logic [DW-1:0] x, logic [DW-1:0] y, int md, output bit [1:0] st);
    longint xr = ln(x,1), xi = ln(x,0), yr = ln(y,1), yi = ln(y,0);
    longint pr, pi;
    bit s1, s0;
    logic [DW-1:0] res;
    case (md)
      0: begin pr = xr*yr - xi*yi; pi = xr*yi + xi*yr; end
      1: begin pr = xr*yr + xi*yi; pi = xr*yi - xi*yr; end
      2: begin pr = xr*yr + xi*yi; pi = xi*yr - xr*yi; end
      default: begin pr = xr*yr; pi = xi*yi; end
    endcase
    res[DW-1:W] = msat(pr >>> (W-1), s1);
    res[W-1:0]  = msat(pi >>> (W-1), s0);
    st = {s1, s0};
    return res;
  endfunction

  function automatic logic [DW-1:0] madd(logic [DW-1:0] x, logic [DW-1:0] s, int fn, bit hv, bit rd,
                                         output bit [1:0] st, output bit [1:0] bg);
    logic [DW-1:0] res;
    for (int g = 0; g < 2; g++) begin
      longint v;
      bit     sv;
      logic [W-1:0] yl;
      case (fn)
        1: v = ln(x,g) - ln(s,g);
        2: v = ln(s,g) - ln(x,g);
        default: v = ln(x,g) + ln(s,g);
      endcase
      if (hv) v = (v + longint'(rd)) >>> 1;
      yl = msat(v, sv);
      st[g] = sv;
      bg[g] = yl[W-1] ^ yl[W-2];
      res[g*W +: W] = yl;
    end
    return res;
  endfunction

  task automatic step(bit en, logic [1:0] ad, logic [DW-1:0] d, logic [CW-1:0] cf,
                      logic [DW-1:0] cof, string tag);
    bit [1:0] ms, ss, ds, sb_, db;
    logic [DW-1:0] mp, sec, sy, dy, na, nb, e2, e3;
    bit [1:0] dummy;
    item_t it;
    @(negedge clk);
    wr_en = en; wr_addr = ad; wr_data = d; cfg = cf; coef_in = cof;
    // combinational values from state before the edge
    mp  = mmul(m_p2, m_p3, int'(cf[5:4]), ms);
    sec = cf[18] ? m_l : mp;
    sy  = madd(m_a, sec, int'(cf[13:12]), cf[1], cf[2], ss, sb_);
    dy  = madd(m_b, sec, int'(cf[15:14]), cf[1], cf[2], ds, db);
    na  = (cf[9:8]   == 2'd1) ? m_p0 : (cf[9:8]   == 2'd2) ? m_s : '0;
    nb  = (cf[11:10] == 2'd1) ? m_p0 : (cf[11:10] == 2'd2) ? m_s : '0;
    if (cf[0]) begin
      m_a = '0; m_b = '0; m_s = '0; m_d = '0; m_q = '0; m_r = '0; m_l = '0; m_fl = '0;
    end else if (en && ad == 2'd3) begin
      m_q = m_s; m_r = m_d; m_a = na; m_b = nb; m_s = sy; m_d = dy; m_l = mp;
      m_fl = m_fl | {sb_[1] | db[1], sb_[0] | db[0], ss[1] | ds[1] | ms[1], ss[0] | ds[0] | ms[0]};
    end
    if (en) begin
      case (ad)
        2'd0: m_p0 = d;
        2'd1: begin m_p1 = d; if (cf[3]) m_p0 = d; end
        2'd2: m_p2 = d;
        default: begin
          m_p3 = d;
          if (cf[7:6] == 2'd1) m_p2 = d;
          else if (cf[7:6] == 2'd2) m_p2 = cof;
        end
      endcase
    end
    e2 = cf[17] ? mmul(m_p2, m_p3, int'(cf[5:4]), dummy) : m_p2;
    e3 = cf[17] ? m_l : m_p3;
    it.v   = {cf[16] ? m_q : m_p0, cf[16] ? m_r : m_p1, e2, e3, m_fl};
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t e;
        logic [VW-1:0] act;
        e   = sb.pop_front();
        act = {rd_p0, rd_p1, rd_p2, rd_p3, big_re, big_im, sat_re, sat_im};
        n_cmp++;
        if (act !== e.v) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", e.tag, act, e.v);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; coef_in = '0; cfg = '0;
    m_p0 = '0; m_p1 = '0; m_p2 = '0; m_p3 = '0; m_a = '0; m_b = '0;
    m_s = '0; m_d = '0; m_q = '0; m_r = '0; m_l = '0; m_fl = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if ({rd_p0, rd_p1, rd_p2, rd_p3, big_re, big_im, sat_re, sat_im} !== '0) begin
      n_bad++;
      $display("FAIL R1: actual %h expected 0",
               {rd_p0, rd_p1, rd_p2, rd_p3, big_re, big_im, sat_re, sat_im});
    end
    rst_n = 1'b1;
    step(0, 0, 0, F_QR | F_MP, 0, "R1");

    // R2: plain port writes and the port-1 duplicate
    step(1, 0, 32'h1234_5678, 0, 0, "R2");
    step(1, 1, 32'h9ABC_DEF0, 0, 0, "R2");
    step(1, 2, 32'h0F0F_F0F0, 0, 0, "R2");
    step(1, 3, 32'h0100_0200, 0, 0, "R2");
    step(1, 1, 32'hAAAA_5555, F_DUP, 0, "R2");
    step(1, 1, 32'h0123_3210, 0, 0, "R2");

    // R3: side effects of a port-3 write on P2
    step(1, 3, 32'h2000_C000, fld(0,1,0,0,0,0), 32'h7777_7777, "R3");
    step(1, 3, 32'h1111_2222, fld(0,2,0,0,0,0), 32'h4000_2000, "R3");
    step(1, 3, 32'h3333_4444, fld(0,0,0,0,0,0), 32'h5555_5555, "R3");
    step(1, 3, 32'h2000_C000, fld(0,3,0,0,0,0), 32'h6666_6666, "R3");

    // R4 / R11: multiplier modes seen through the product read select
    for (int mm = 0; mm < 4; mm++) step(0, 0, 0, F_MP | fld(mm,0,0,0,0,0), 0, "R4");
    step(1, 2, 32'hE000_3000, 0, 0, "R4");
    for (int mm = 0; mm < 4; mm++) step(0, 0, 0, F_MP | fld(mm,0,0,0,0,0), 0, "R4");
    step(0, 0, 0, F_QR | F_MP, 0, "R11");

    // R5 / R6: butterfly steps with adder directions
    step(1, 0, 32'h3000_1000, 0, 0, "R5");
    step(1, 3, 32'h1000_F000, F_QR | fld(0,0,1,1,0,1), 0, "R5");
    step(1, 3, 32'h0800_0400, F_QR | fld(1,0,1,2,1,2), 0, "R6");
    step(1, 3, 32'hF800_0C00, F_QR | fld(2,0,2,1,2,0), 0, "R6");
    step(1, 3, 32'h0000_0000, F_QR | fld(0,0,1,1,3,3), 0, "R6");
    step(0, 0, 0, F_QR | F_MP, 0, "R5");

    // R7: halving and rounding with a zero product
    step(1, 0, 0, F_CLR, 0, "R10");
    step(1, 2, 0, 0, 0, "R7");
    step(1, 0, 32'h0003_FFFD, 0, 0, "R7");
    step(1, 3, 32'h1234_4321, fld(0,0,1,1,0,1), 0, "R7");
    step(1, 3, 32'h1234_4321, F_QR | F_HV | F_RD | fld(0,0,1,1,0,1), 0, "R7");
    step(1, 3, 32'h1234_4321, F_QR | F_HV | fld(0,0,1,1,0,1), 0, "R7");
    step(1, 3, 32'h1234_4321, F_QR | F_RD | fld(0,0,1,1,0,1), 0, "R7");
    step(1, 3, 32'h1234_4321, F_QR | fld(0,0,1,1,0,1), 0, "R7");

    // R8: full-scale negative squared saturates the product
    step(1, 0, 0, F_CLR, 0, "R10");
    step(1, 2, 32'h8000_0000, 0, 0, "R8");
    step(1, 3, 32'h8000_0000, 0, 0, "R8");
    step(1, 3, 32'h8000_0000, F_MP, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    step(1, 0, 32'h7FFF_7FFF, F_CLR, 0, "R10");
    step(1, 3, 32'h4000_4000, fld(3,1,1,1,0,0), 0, "R8");
    step(1, 3, 32'h7FFF_7FFF, fld(3,1,1,1,0,1), 0, "R8");

    // R9: large-value flags
    step(1, 0, 0, F_CLR, 0, "R10");
    step(1, 2, 0, 0, 0, "R9");
    step(1, 0, 32'h5000_0100, 0, 0, "R9");
    step(1, 3, 0, fld(0,0,1,0,0,0), 0, "R9");
    step(1, 3, 0, fld(0,0,1,0,0,0), 0, "R9");
    step(0, 0, 0, 0, 0, "R9");
    step(1, 0, 32'h0100_C000, 0, 0, "R9");
    step(1, 3, 0, fld(0,0,1,1,0,0), 0, "R9");
    step(1, 3, 0, fld(0,0,1,1,0,0), 0, "R9");

    // R10: clear with a concurrent port write
    step(1, 0, 32'h0A0A_0B0B, F_CLR | F_QR | F_MP, 0, "R10");
    step(1, 3, 32'h4000_4000, F_CLR | F_QR | F_MP, 0, "R10");
    step(0, 0, 0, F_MP, 0, "R10");

    // R12: second operand from L
    step(1, 2, 32'h4000_2000, 0, 0, "R12");
    step(1, 3, 32'h4000_E000, F_UL | F_QR, 0, "R12");
    step(1, 3, 32'h2000_2000, F_UL | F_QR | fld(1,0,0,0,1,2), 0, "R12");
    step(1, 3, 32'h1000_3000, F_UL | F_QR | F_MP, 0, "R12");
    step(1, 3, 32'h1000_3000, F_QR | F_MP, 0, "R12");

    // mixed traffic over all steering choices
    for (int i = 0; i < 400; i++) begin
      logic [CW-1:0] cf = CW'($urandom);
      if (cf[7:6] == 2'd3) cf[7:6] = 2'd0;
      cf[0] = (($urandom % 16) == 0);
      step(($urandom % 8) != 0, 2'($urandom), DW'($urandom), cf, DW'($urandom), "R5 mixed");
    end
    step(0, 0, 0, 0, 0, "R5");

    while (sb.size() > 0) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule